// File: doc/BRIEF.md
# Paced Transmit Queue with Pin Control

This block is the outgoing side of a byte-stream link toward a host. Producers write whole packets into a circular byte buffer. The block releases the buffered bytes toward the host one at a time, with exactly one byte per configured interval. Packets that arrive from the controller side are tagged as event or ACL packets. For these, the block inserts a leading type byte and pads the stored packet to an even length. Device-generated packets are tagged raw and are stored exactly as written.

The block also models the device's control lines. Two input pins, a power pin and a reset pin, decide when the device is enabled and when it is wiped back to its reset state. A two-bit modem-status register holds RTS and CTS. A write that drops RTS also withdraws CTS, and loading a new byte interval raises CTS.

Internally there are three state machines. The write state machine has three states. In WR_IDLE it waits for a start-of-packet beat. It moves to WR_BODY while a packet that still fits is being stored, and to WR_DROP once a packet no longer fits. It returns to WR_IDLE on the end-of-packet beat. The pacer has two states. It goes from PACE_IDLE to PACE_RUN when the device is enabled and the queue holds data, and back to PACE_IDLE when either stops being true. The device state machine moves from DEV_OFF to DEV_ON when both pins reach high together, and back to DEV_OFF on a falling edge of the reset pin.

Top module: `ptq_top`

## Requirements
- R1: While the device is enabled and the queue holds committed bytes, one byte is presented on `tx_data` with `tx_valid` high for one cycle. Consecutive bytes are exactly N cycles apart, where N is the current interval. Bytes leave in the order they were written.
- R2: After `rst_n` is released, the following hold: the interval is `CLK_HZ` cycles (one second), `mdm_rdata` reads 2'b01 (bit 0 = CTS, bit 1 = RTS), the queue is empty, the device is disabled, and `ovf` is 0.
- R3: A `cfg_wr` pulse loads `cfg_div` as the interval in cycles and sets CTS. A value of 0 acts as 1.
- R4: A `mdm_wr` pulse loads `mdm_wdata` into the modem-status register. If that write takes RTS (bit 1) from 1 to 0, CTS (bit 0) reads 0 afterwards, whatever value was written to bit 0.
- R5: A falling edge on `pin_rst` returns the block to the R2 state. The queue and any packet still being written are discarded.
- R6: The device becomes enabled in the cycle after {`pin_rst`,`pin_pwr`} becomes 2'b11 from any other value. No byte is sent while the device is disabled, and queued bytes are kept.
- R7: The write kind is given by `wr_kind`. For kind 1 (event), the byte 0x04 is stored ahead of the payload. For kind 2 (ACL), the byte 0x02 is stored ahead of the payload. For both of these kinds, a 0x00 byte is appended when the stored length including the type byte is odd. Kinds 0 and 3 (raw) are stored unchanged.
- R8: A packet that does not fit in the free space (`QDEPTH` bytes total) is dropped whole, and `ovf` becomes 1 and stays 1 until a reset. Later packets that fit are still accepted.
- R9: Pacing starts when the queue becomes non-empty while the device is enabled. The first byte appears N cycles after the edge that commits the packet. Pacing stops when the last byte leaves, so a later packet again waits a full interval.
- R10: No byte of a packet can leave before its end-of-packet beat. Bytes are committed only on that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write beat valid |
| wr_sop | input | 1 | First beat of a packet |
| wr_eop | input | 1 | Last beat of a packet |
| wr_kind | input | 2 | Packet kind, sampled with `wr_sop` (0/3 raw, 1 event, 2 ACL) |
| wr_data | input | 8 | Payload byte |
| cfg_wr | input | 1 | Load a new byte interval |
| cfg_div | input | DIV_W | Interval in clock cycles |
| pin_pwr | input | 1 | Power/wake control pin |
| pin_rst | input | 1 | Reset control pin (falling edge resets) |
| mdm_wr | input | 1 | Modem-status write strobe |
| mdm_wdata | input | 2 | Modem-status write value {RTS, CTS} |
| mdm_rdata | output | 2 | Modem-status read value {RTS, CTS} |
| tx_valid | output | 1 | Byte valid toward the host |
| tx_data | output | 8 | Byte toward the host |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The bench measures the number of cycles from the commit edge, and from the enable edge, to the first byte. A pacer that keeps counting across an idle gap, or that starts counting one cycle late, shows up as a gap that is off by one or shorter than the interval. A packet held open across a long pause before its end beat must not leak bytes early. A design that commits bytes on each beat would emit them during the pause. When the queue overflows with packets that exactly fill the remaining room, the bench expects a partly written packet to vanish whole while the next exact-fit packet is kept. A design that stores part of the dropped packet, or that computes the room off by one, would corrupt the scoreboard order. A reset-pin edge in the middle of a packet must erase everything, including the interval and CTS. The trailing beats of the abandoned packet must then be ignored.

// File: rtl/ptq_pkg.sv
package ptq_pkg;

    localparam logic [1:0] KIND_RAW = 2'd0;
    localparam logic [1:0] KIND_EVT = 2'd1;
    localparam logic [1:0] KIND_ACL = 2'd2;

    localparam int MDM_CTS = 0;
    localparam int MDM_RTS = 1;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_BODY,
        WR_DROP
    } wr_state_e;

    typedef enum logic {
        PACE_IDLE,
        PACE_RUN
    } pace_state_e;

    typedef enum logic {
        DEV_OFF,
        DEV_ON
    } dev_state_e;

    function automatic logic [7:0] type_byte(input logic [1:0] kind);
        case (kind)
            KIND_EVT: return 8'h04;
            KIND_ACL: return 8'h02;
            default:  return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/ptq_ctrl.sv
module ptq_ctrl
    import ptq_pkg::*;
#(
    parameter int CLK_HZ = 125_000_000,
    parameter int DIV_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             pin_pwr,
    input  logic             pin_rst,
    input  logic             mdm_wr,
    input  logic [1:0]       mdm_wdata,
    output logic             srst,
    output logic             en,
    output logic [DIV_W-1:0] div_eff,
    output logic [1:0]       mdm_rdata
);

    dev_state_e       dst, dst_n;
    logic [1:0]       pins_q;
    logic [1:0]       pins_now;
    logic             both_rise;
    logic             cts, rts;
    logic [DIV_W-1:0] div_q;

    assign pins_now  = {pin_rst, pin_pwr};
    assign srst      = pins_q[1] & ~pin_rst;
    assign both_rise = (pins_now == 2'b11) && (pins_q != 2'b11);

    // device state transitions
    always_comb begin
        dst_n = dst;
        unique case (dst)
            DEV_OFF: if (both_rise) dst_n = DEV_ON;
            DEV_ON:  dst_n = DEV_ON;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dst    <= DEV_OFF;
            pins_q <= 2'b00;
        end else begin
            pins_q <= pins_now;
            dst    <= srst ? DEV_OFF : dst_n;
        end
    end

    // modem status and interval
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cts   <= 1'b1;
            rts   <= 1'b0;
            div_q <= DIV_W'(CLK_HZ);
        end else if (srst) begin
            cts   <= 1'b1;
            rts   <= 1'b0;
            div_q <= DIV_W'(CLK_HZ);
        end else begin
            if (mdm_wr) begin
                rts <= mdm_wdata[MDM_RTS];
                cts <= (rts && !mdm_wdata[MDM_RTS]) ? 1'b0 : mdm_wdata[MDM_CTS];
            end
            if (cfg_wr) begin
                cts   <= 1'b1;
                div_q <= cfg_div;
            end
        end
    end

    always_comb begin
        en        = (dst == DEV_ON);
        div_eff   = (div_q == '0) ? DIV_W'(1) : div_q;
        mdm_rdata = {rts, cts};
    end

    AST_CTS_ON_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !srst) |=> mdm_rdata[MDM_CTS]); // R3
    AST_CTS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (mdm_wr && !cfg_wr && !srst && mdm_rdata[MDM_RTS] && !mdm_wdata[MDM_RTS])
        |=> !mdm_rdata[MDM_CTS]); // R4
    AST_ENABLE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && pin_pwr && pin_rst && !(pins_q == 2'b11)) |=> en); // R6
    AST_SRST_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!en && mdm_rdata == 2'b01)); // R5

endmodule

// File: rtl/ptq_writer.sv
module ptq_writer
    import ptq_pkg::*;
#(
    parameter int QDEPTH = 4096,
    parameter int AW     = $clog2(QDEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_valid,
    input  logic          wr_sop,
    input  logic          wr_eop,
    input  logic [1:0]    wr_kind,
    input  logic [7:0]    wr_data,
    input  logic [AW:0]   used,
    output logic          we0,
    output logic          we1,
    output logic [AW-1:0] a0,
    output logic [AW-1:0] a1,
    output logic [7:0]    d0,
    output logic [7:0]    d1,
    output logic          commit,
    output logic [AW:0]   commit_len,
    output logic          ovf
);

    localparam int CW = AW + 2;

    wr_state_e     st, st_n;
    logic [CW-1:0] pend, pend_n;
    logic [AW-1:0] tail, tail_n, wptr, wptr_n;
    logic [1:0]    kind_q, kind_n, kind_now;
    logic          ovf_n;

    logic          beat_start, beat_body, accept, pref, pad, fits;
    logic [1:0]    nb;
    logic [CW-1:0] base, pre_pad, total, room;

    // beat decode
    always_comb begin
        beat_start = (st == WR_IDLE) && wr_valid && wr_sop;
        beat_body  = (st == WR_BODY) && wr_valid;
        accept     = beat_start || beat_body;
        kind_now   = beat_start ? wr_kind : kind_q;
        pref       = beat_start && (wr_kind == KIND_EVT || wr_kind == KIND_ACL);
        base       = beat_start ? '0 : pend;
        pre_pad    = base + (pref ? CW'(2) : CW'(1));
        pad        = wr_eop && (kind_now == KIND_EVT || kind_now == KIND_ACL) && pre_pad[0];
        nb         = (pref || pad) ? 2'd2 : 2'd1;
        total      = base + CW'(nb);
        room       = CW'(QDEPTH) - CW'(used);
        fits       = (total <= room);
    end

    // output process
    always_comb begin
        a0         = beat_start ? tail : wptr;
        a1         = a0 + AW'(1);
        d0         = pref ? type_byte(wr_kind) : wr_data;
        d1         = pref ? wr_data : 8'h00;
        we0        = accept && fits && !clr;
        we1        = we0 && (nb == 2'd2);
        commit     = we0 && wr_eop;
        commit_len = total[AW:0];
    end

    // next-state process
    always_comb begin
        st_n   = st;
        pend_n = pend;
        tail_n = tail;
        wptr_n = wptr;
        kind_n = kind_q;
        ovf_n  = ovf;
        unique case (st)
            WR_IDLE, WR_BODY: begin
                if (accept) begin
                    if (beat_start) kind_n = wr_kind;
                    if (fits) begin
                        if (wr_eop) begin
                            tail_n = a0 + AW'(nb);
                            pend_n = '0;
                            st_n   = WR_IDLE;
                        end else begin
                            wptr_n = a0 + AW'(nb);
                            pend_n = total;
                            st_n   = WR_BODY;
                        end
                    end else if (wr_eop) begin
                        ovf_n  = 1'b1;
                        pend_n = '0;
                        st_n   = WR_IDLE;
                    end else begin
                        st_n = WR_DROP;
                    end
                end
            end
            WR_DROP: begin
                if (wr_valid && wr_eop) begin
                    ovf_n  = 1'b1;
                    pend_n = '0;
                    st_n   = WR_IDLE;
                end
            end
            default: st_n = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= WR_IDLE;
            pend   <= '0;
            tail   <= '0;
            wptr   <= '0;
            kind_q <= KIND_RAW;
            ovf    <= 1'b0;
        end else if (clr) begin
            st     <= WR_IDLE;
            pend   <= '0;
            tail   <= '0;
            wptr   <= '0;
            kind_q <= KIND_RAW;
            ovf    <= 1'b0;
        end else begin
            st     <= st_n;
            pend   <= pend_n;
            tail   <= tail_n;
            wptr   <= wptr_n;
            kind_q <= kind_n;
            ovf    <= ovf_n;
        end
    end

    AST_EVEN_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && (kind_q == KIND_EVT || kind_q == KIND_ACL) && st == WR_BODY)
        |-> !commit_len[0]); // R7
    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WR_DROP) |-> !we0); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf); // R8

endmodule

// File: rtl/ptq_store.sv
module ptq_store #(
    parameter int QDEPTH = 4096,
    parameter int AW     = $clog2(QDEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we0,
    input  logic          we1,
    input  logic [AW-1:0] a0,
    input  logic [AW-1:0] a1,
    input  logic [7:0]    d0,
    input  logic [7:0]    d1,
    input  logic          commit,
    input  logic [AW:0]   commit_len,
    input  logic          pop,
    output logic [AW:0]   used,
    output logic          tx_valid,
    output logic [7:0]    tx_data
);

    logic [7:0]    mem [QDEPTH];
    logic [AW-1:0] head;
    logic [AW:0]   used_n;

    always_ff @(posedge clk) begin
        if (we0) mem[a0] <= d0;
        if (we1) mem[a1] <= d1;
    end

    always_comb begin
        used_n = used + (commit ? commit_len : '0) - {{AW{1'b0}}, pop};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            used     <= '0;
            head     <= '0;
            tx_valid <= 1'b0;
            tx_data  <= 8'h00;
        end else if (clr) begin
            used     <= '0;
            head     <= '0;
            tx_valid <= 1'b0;
        end else begin
            used     <= used_n;
            tx_valid <= pop;
            if (pop) begin
                tx_data <= mem[head];
                head    <= head + AW'(1);
            end
        end
    end

    AST_USED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        used <= (AW+1)'(QDEPTH)); // R8
    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (used == '0 && !tx_valid)); // R5
    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (used != '0)); // R1

endmodule

// File: rtl/ptq_pacer.sv
module ptq_pacer
    import ptq_pkg::*;
#(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             nonempty,
    input  logic [DIV_W-1:0] div,
    output logic             pop
);

    pace_state_e      st, st_n;
    logic [DIV_W-1:0] cnt, cnt_n;
    logic             active, due;

    always_comb begin
        active = en && nonempty;
        due    = (cnt >= div - DIV_W'(1));
    end

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        pop   = 1'b0;
        unique case (st)
            PACE_IDLE: begin
                if (active) begin
                    pop   = due;
                    cnt_n = due ? '0 : cnt + DIV_W'(1);
                    st_n  = PACE_RUN;
                end
            end
            PACE_RUN: begin
                if (!active) begin
                    cnt_n = '0;
                    st_n  = PACE_IDLE;
                end else begin
                    pop   = due;
                    cnt_n = due ? '0 : cnt + DIV_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= PACE_IDLE;
            cnt <= '0;
        end else if (clr) begin
            st  <= PACE_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PACE_IDLE) |-> (cnt == '0)); // R9
    AST_POP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> en); // R6

endmodule

// File: rtl/ptq_top.sv
module ptq_top #(
    parameter int QDEPTH = 4096,
    parameter int CLK_HZ = 125_000_000,
    parameter int DIV_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic             wr_sop,
    input  logic             wr_eop,
    input  logic [1:0]       wr_kind,
    input  logic [7:0]       wr_data,
    input  logic             cfg_wr,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             pin_pwr,
    input  logic             pin_rst,
    input  logic             mdm_wr,
    input  logic [1:0]       mdm_wdata,
    output logic [1:0]       mdm_rdata,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             ovf
);

    localparam int AW = $clog2(QDEPTH);

    logic             srst, en, pop;
    logic [DIV_W-1:0] div_eff;
    logic [AW:0]      used, commit_len;
    logic             we0, we1, commit;
    logic [AW-1:0]    a0, a1;
    logic [7:0]       d0, d1;

    ptq_ctrl #(.CLK_HZ(CLK_HZ), .DIV_W(DIV_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_div(cfg_div),
        .pin_pwr(pin_pwr), .pin_rst(pin_rst), .mdm_wr(mdm_wr),
        .mdm_wdata(mdm_wdata), .srst(srst), .en(en), .div_eff(div_eff),
        .mdm_rdata(mdm_rdata)
    );

    ptq_writer #(.QDEPTH(QDEPTH), .AW(AW)) u_writer (
        .clk(clk), .rst_n(rst_n), .clr(srst), .wr_valid(wr_valid),
        .wr_sop(wr_sop), .wr_eop(wr_eop), .wr_kind(wr_kind), .wr_data(wr_data),
        .used(used), .we0(we0), .we1(we1), .a0(a0), .a1(a1), .d0(d0), .d1(d1),
        .commit(commit), .commit_len(commit_len), .ovf(ovf)
    );

    ptq_store #(.QDEPTH(QDEPTH), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(srst), .we0(we0), .we1(we1),
        .a0(a0), .a1(a1), .d0(d0), .d1(d1), .commit(commit),
        .commit_len(commit_len), .pop(pop), .used(used),
        .tx_valid(tx_valid), .tx_data(tx_data)
    );

    ptq_pacer #(.DIV_W(DIV_W)) u_pacer (
        .clk(clk), .rst_n(rst_n), .clr(srst), .en(en),
        .nonempty(used != '0), .div(div_eff), .pop(pop)
    );

    AST_TX_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> en); // R6

endmodule

// File: tb/ptq_top_bench.sv
module ptq_top_bench;

    localparam int QD  = 16;
    localparam int CHZ = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 0, wr_sop = 0, wr_eop = 0;
    logic [1:0]  wr_kind = 0;
    logic [7:0]  wr_data = 0;
    logic        cfg_wr = 0;
    logic [31:0] cfg_div = 0;
    logic        pin_pwr = 0, pin_rst = 0;
    logic        mdm_wr = 0;
    logic [1:0]  mdm_wdata = 0;
    logic [1:0]  mdm_rdata;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        ovf;

    always #4 clk = ~clk;

    ptq_top #(.QDEPTH(QD), .CLK_HZ(CHZ), .DIV_W(32)) u_ptq_top (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sop(wr_sop),
        .wr_eop(wr_eop), .wr_kind(wr_kind), .wr_data(wr_data),
        .cfg_wr(cfg_wr), .cfg_div(cfg_div), .pin_pwr(pin_pwr),
        .pin_rst(pin_rst), .mdm_wr(mdm_wr), .mdm_wdata(mdm_wdata),
        .mdm_rdata(mdm_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .ovf(ovf)
    );

    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;
    logic [7:0] exp_q[$];
    int   tx_t[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: scoreboard compare and timestamp
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            tx_t.push_back(cyc);
            if (exp_q.size() == 0)
                check(1'b0, "R1", "unexpected byte", int'(tx_data), -1);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(tx_data == e, "R1/R7", "byte content", int'(tx_data), int'(e));
            end
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // driver: pushes expected bytes, then writes the packet
    task automatic send_pkt(input logic [1:0] kind, input int n, input logic [7:0] seed,
                            input int hold, input bit drop, output int commit_cyc);
        bit pref;
        pref = (kind == 2'd1) || (kind == 2'd2);
        if (!drop) begin
            if (kind == 2'd1) exp_q.push_back(8'h04);
            if (kind == 2'd2) exp_q.push_back(8'h02);
            for (int i = 0; i < n; i++) exp_q.push_back(seed + 8'(i));
            if (pref && ((n + 1) % 2 == 1)) exp_q.push_back(8'h00);
        end
        for (int i = 0; i < n; i++) begin
            if (i == n - 1 && hold > 0) begin
                wr_valid = 0;
                tick(hold);
            end
            wr_valid = 1;
            wr_sop   = (i == 0);
            wr_eop   = (i == n - 1);
            wr_kind  = kind;
            wr_data  = seed + 8'(i);
            tick();
        end
        commit_cyc = cyc;
        wr_valid = 0; wr_sop = 0; wr_eop = 0;
    endtask

    task automatic wait_tx(output int t);
        while (tx_t.size() == 0) tick();
        t = tx_t.pop_front();
    endtask

    task automatic drain();
        while (exp_q.size() != 0) tick();
        tick(3);
        tx_t.delete();
    endtask

    task automatic mdm_write(input logic [1:0] v);
        mdm_wr = 1; mdm_wdata = v; tick(); mdm_wr = 0;
    endtask

    task automatic cfg_write(input int v);
        cfg_wr = 1; cfg_div = v; tick(); cfg_wr = 0;
    endtask

    initial begin
        int c, t, t2, e;
        tick(3);
        rst_n = 1;
        tick();
        // R2 reset state
        check(mdm_rdata == 2'b01, "R2", "modem status after reset", mdm_rdata, 1);
        check(tx_valid == 0, "R2", "tx idle after reset", tx_valid, 0);
        check(ovf == 0, "R2", "ovf after reset", ovf, 0);

        // R6 disabled: nothing sent, bytes kept
        send_pkt(2'd0, 3, 8'h10, 0, 0, c);
        tick(100);
        check(tx_t.size() == 0, "R6", "bytes sent while disabled", tx_t.size(), 0);

        // R6 enable on both pins high, R2 one-second interval
        pin_rst = 1; tick();
        pin_pwr = 1; e = cyc + 1; tick();
        wait_tx(t);
        check(t - e == CHZ, "R2", "first byte after enable", t - e, CHZ);
        wait_tx(t2);
        check(t2 - t == CHZ, "R1", "byte spacing", t2 - t, CHZ);
        drain();

        // R4 modem status
        mdm_write(2'b11);
        check(mdm_rdata == 2'b11, "R4", "plain modem write", mdm_rdata, 3);
        mdm_write(2'b01);
        check(mdm_rdata == 2'b00, "R4", "CTS after RTS fall", mdm_rdata, 0);
        mdm_write(2'b01);
        check(mdm_rdata == 2'b01, "R4", "CTS write with RTS low", mdm_rdata, 1);
        mdm_write(2'b10);
        check(mdm_rdata == 2'b10, "R4", "RTS rise keeps written CTS", mdm_rdata, 2);
        // R3 interval load sets CTS
        cfg_write(5);
        check(mdm_rdata == 2'b11, "R3", "CTS after interval load", mdm_rdata, 3);

        // R7 event with prefix, R9 start from commit
        send_pkt(2'd1, 3, 8'h20, 0, 0, c);
        wait_tx(t);
        check(t - c == 5, "R9", "first byte after commit", t - c, 5);
        wait_tx(t2);
        check(t2 - t == 5, "R1", "spacing at interval 5", t2 - t, 5);
        drain();
        tick(20);
        // R7 ACL with pad, R9 restart after idle
        send_pkt(2'd2, 2, 8'h30, 0, 0, c);
        wait_tx(t);
        check(t - c == 5, "R9", "full interval after idle", t - c, 5);
        drain();
        send_pkt(2'd2, 1, 8'h38, 0, 0, c);
        send_pkt(2'd1, 2, 8'h3c, 0, 0, c);
        send_pkt(2'd3, 3, 8'h3e, 0, 0, c);
        drain();

        // R10 no byte before end beat
        send_pkt(2'd0, 3, 8'h40, 30, 0, c);
        wait_tx(t);
        check(t - c == 5, "R10", "first byte of held packet", t - c, 5);
        drain();

        // R3 zero interval acts as one
        cfg_write(0);
        send_pkt(2'd0, 3, 8'h48, 0, 0, c);
        wait_tx(t);
        wait_tx(t2);
        check(t2 - t == 1, "R3", "spacing with zero interval", t2 - t, 1);
        drain();

        // R8 overflow: drop whole, sticky, later fit accepted
        cfg_write(3000);
        send_pkt(2'd0, 10, 8'h50, 0, 0, c);
        check(ovf == 0, "R8", "ovf after fitting packet", ovf, 0);
        send_pkt(2'd0, 10, 8'h60, 0, 1, c);
        check(ovf == 1, "R8", "ovf after oversize packet", ovf, 1);
        send_pkt(2'd0, 6, 8'h70, 0, 0, c);
        send_pkt(2'd0, 1, 8'h80, 0, 1, c);
        cfg_write(2);
        drain();
        check(ovf == 1, "R8", "ovf sticky", ovf, 1);

        // R5 reset pin falling edge mid-packet
        cfg_write(3000);
        send_pkt(2'd0, 4, 8'h90, 0, 1, c);
        wr_valid = 1; wr_sop = 1; wr_kind = 2'd1; wr_data = 8'h99; tick();
        wr_sop = 0; wr_data = 8'h9a; tick();
        wr_valid = 0;
        mdm_write(2'b10);
        pin_rst = 0; tick();
        check(mdm_rdata == 2'b01, "R5", "modem status after pin reset", mdm_rdata, 1);
        check(ovf == 0, "R5", "ovf after pin reset", ovf, 0);
        wr_valid = 1; wr_eop = 1; wr_data = 8'h9b; tick();
        wr_valid = 0; wr_eop = 0;
        tick(5);
        check(tx_t.size() == 0, "R5", "bytes after pin reset", tx_t.size(), 0);
        pin_rst = 1; tick(2);
        send_pkt(2'd0, 2, 8'ha0, 0, 0, c);
        wait_tx(t);
        check(t - c == CHZ, "R5", "interval restored", t - c, CHZ);
        drain();
        tick(50);
        check(exp_q.size() == 0, "R1", "bytes still expected", exp_q.size(), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog expired: got %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule